// File: doc/BRIEF.md
# Sticky Interrupt Cause Register with Message Vector Encoding

This block collects single-cycle event pulses from the rest of a device into a sticky cause register that the host can read. The host clears a cause by writing 1 to its bit. A second host register chooses which causes may reach the interrupt line, and a global enable bit in a control register gates them all. When at least one enabled cause is pending, the block raises a level interrupt. In the same cycle it reports a message-signalled interrupt number for the lowest-numbered pending cause that has one.

The host reaches the three registers through a simple write port and a combinational read port, both addressed by byte offset. The cause register is at offset 0x520, the enable mask at 0x528 and the control register at 0x500. The offsets are parameters. A small two-state machine drives the interrupt output. In `ST_QUIET` the line is low. The transition `GO_RAISED` moves the machine to `ST_RAISED`, where the line is high, when an enabled cause is pending. The transition `GO_QUIET` moves it back once no enabled cause is pending.

Top module: `hif_irq_ctrl`

## Requirements
- R1: After reset, or when reset is applied later, the cause, mask and control registers all read 0 and `irq_o` and `msi_vld_o` are 0.
- R2: A 1 on `ev_i[b]` at a clock edge sets cause bit b. The bit reads back as 1 on the next read and stays 1 until the host clears it.
- R3: A host write to offset 0x520 clears every cause bit where the write data has a 1 and leaves every bit where it has a 0 unchanged.
- R4: When an event and a host clear hit the same cause bit in the same cycle, the bit ends up set.
- R5: Cause bits 3, 4 and 11..31 are never set, including by event inputs 3 and 4, and always read 0. The mask register implements only bits 0..2 and 5..10, so a write of all ones reads back as 0x7E7. The control register keeps only bit 7, so a write of all ones reads back as 0x80.
- R6: Writing the mask or control register never changes the cause register.
- R7: `irq_o` is 1 exactly one cycle after a clock edge at which (cause AND mask) is nonzero and control bit 7 is 1. Otherwise it is 0 one cycle after that edge.
- R8: When `irq_o` is 1 and the lowest-numbered enabled pending cause b is one of bits 0..2 or 5..8, `msi_vld_o` is 1 and `msi_num_o` is b+4. This maps bits 0, 1 and 2 to 4, 5 and 6, and bits 5 to 8 to 9 to 12.
- R9: When the lowest enabled pending cause is bit 9 (overrun) or bit 10 (bad ROM read), `irq_o` is 1 and `msi_vld_o` is 0.
- R10: Writes to any offset other than 0x500, 0x520 and 0x528 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_i | input | 11 | Event pulses, one per cause bit |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 12 | Host write byte offset |
| wr_data_i | input | 32 | Host write data |
| rd_addr_i | input | 12 | Host read byte offset |
| rd_data_o | output | 32 | Read data, combinational from `rd_addr_i` |
| irq_o | output | 1 | Level interrupt |
| msi_vld_o | output | 1 | `msi_num_o` holds a valid message number |
| msi_num_o | output | 4 | Message number of the lowest enabled pending cause |

## Verification
Register effects (R2 to R6 and R10) are due at the clock edge that samples the write or the event. The bench drives its stimulus on a falling edge and reads the register back at the next falling edge. `irq_o`, `msi_vld_o` and `msi_num_o` pass through one more register, so they reflect the state one edge after the register change. The bench therefore checks them at the first falling edge, expecting the old value, and again at the second, expecting the new value. The bound checker states the same one-cycle relation for the interrupt line.

// File: rtl/hif_irq_pkg.sv
package hif_irq_pkg;
    localparam int CAUSE_W  = 11;
    localparam int IDX_W    = $clog2(CAUSE_W);
    localparam int MSI_W    = 4;
    localparam int MSI_BASE = 4;
    localparam int GIE_BIT  = 7;
    // causes that exist: 0..2 and 5..10
    localparam logic [CAUSE_W-1:0] CAUSE_VALID = 11'b111_1110_0111;
    // causes owning a message number: 0..2 and 5..8
    localparam logic [CAUSE_W-1:0] MSI_CAPABLE = 11'b001_1110_0111;

    typedef enum logic [0:0] {
        ST_QUIET  = 1'b0,
        ST_RAISED = 1'b1
    } irq_st_e;
endpackage

// File: rtl/hif_irq_regs.sv
module hif_irq_regs
    import hif_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h520,
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h528,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h500
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] ev_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic [CAUSE_W-1:0] status_q,
    output logic [CAUSE_W-1:0] mask_q,
    output logic               gie_q
);
    localparam int PAD_W = DATA_W - CAUSE_W;

    logic               hit_stat, hit_mask, hit_ctrl;
    logic [CAUSE_W-1:0] clr_bits, status_d;
    logic               unused_wr_hi;

    assign hit_stat = wr_en_i && (wr_addr_i == STAT_OFS);
    assign hit_mask = wr_en_i && (wr_addr_i == MASK_OFS);
    assign hit_ctrl = wr_en_i && (wr_addr_i == CTRL_OFS);
    assign unused_wr_hi = ^wr_data_i[DATA_W-1:CAUSE_W];

    // set beats clear: events are ORed in after the clear
    assign clr_bits = hit_stat ? wr_data_i[CAUSE_W-1:0] : '0;
    assign status_d = ((status_q & ~clr_bits) | ev_i) & CAUSE_VALID;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
            mask_q   <= '0;
            gie_q    <= 1'b0;
        end else begin
            status_q <= status_d;
            if (hit_mask) mask_q <= wr_data_i[CAUSE_W-1:0] & CAUSE_VALID;
            if (hit_ctrl) gie_q  <= wr_data_i[GIE_BIT];
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == STAT_OFS)
            rd_data_o = {{PAD_W{1'b0}}, status_q};
        else if (rd_addr_i == MASK_OFS)
            rd_data_o = {{PAD_W{1'b0}}, mask_q};
        else if (rd_addr_i == CTRL_OFS)
            rd_data_o[GIE_BIT] = gie_q;
    end
endmodule

// File: rtl/hif_irq_prio.sv
module hif_irq_prio
    import hif_irq_pkg::*;
(
    input  logic [CAUSE_W-1:0] pend_i,
    output logic               any_o,
    output logic               has_num_o,
    output logic [MSI_W-1:0]   num_o
);
    logic [IDX_W-1:0] idx;

    // scan high to low so the lowest set bit is written last
    always_comb begin
        idx = '0;
        for (int b = CAUSE_W - 1; b >= 0; b--) begin
            if (pend_i[b]) idx = IDX_W'(b);
        end
    end

    assign any_o     = |pend_i;
    assign has_num_o = any_o && MSI_CAPABLE[idx];
    assign num_o     = MSI_W'(idx) + MSI_W'(MSI_BASE);
endmodule

// File: rtl/hif_irq_fsm.sv
module hif_irq_fsm
    import hif_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pend_any_i,
    input  logic             has_num_i,
    input  logic [MSI_W-1:0] num_i,
    output logic             irq_o,
    output logic             msi_vld_o,
    output logic [MSI_W-1:0] msi_num_o
);
    irq_st_e          state_q, state_d;
    logic             cap_q;
    logic [MSI_W-1:0] num_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:  if (pend_any_i)  state_d = ST_RAISED; // GO_RAISED
            ST_RAISED: if (!pend_any_i) state_d = ST_QUIET;  // GO_QUIET
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            cap_q   <= 1'b0;
            num_q   <= '0;
        end else begin
            state_q <= state_d;
            cap_q   <= has_num_i;
            num_q   <= num_i;
        end
    end

    always_comb begin
        irq_o     = (state_q == ST_RAISED);
        msi_vld_o = irq_o && cap_q;
        msi_num_o = msi_vld_o ? num_q : '0;
    end
endmodule

// File: rtl/hif_irq_ctrl.sv
module hif_irq_ctrl
    import hif_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h520,
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h528,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h500
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] ev_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic               irq_o,
    output logic               msi_vld_o,
    output logic [MSI_W-1:0]   msi_num_o
);
    logic [CAUSE_W-1:0] status_q, mask_q, pend;
    logic               gie_q, any, has_num;
    logic [MSI_W-1:0]   num;

    hif_irq_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS), .CTRL_OFS(CTRL_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .status_q(status_q), .mask_q(mask_q), .gie_q(gie_q)
    );

    assign pend = gie_q ? (status_q & mask_q) : '0;

    hif_irq_prio u_prio (
        .pend_i(pend), .any_o(any), .has_num_o(has_num), .num_o(num)
    );

    hif_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pend_any_i(any), .has_num_i(has_num), .num_i(num),
        .irq_o(irq_o), .msi_vld_o(msi_vld_o), .msi_num_o(msi_num_o)
    );
endmodule

// File: rtl/hif_irq_ctrl_chk.sv
module hif_irq_ctrl_chk
    import hif_irq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h520,
    parameter logic [ADDR_W-1:0] MASK_OFS = 12'h528
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CAUSE_W-1:0] ev_i,
    input logic               wr_en_i,
    input logic [ADDR_W-1:0]  wr_addr_i,
    input logic [CAUSE_W-1:0] wr_lo_i,
    input logic [CAUSE_W-1:0] status_q,
    input logic [CAUSE_W-1:0] mask_q,
    input logic               gie_q,
    input logic               irq_o,
    input logic               msi_vld_o,
    input logic [MSI_W-1:0]   msi_num_o
);
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ev_i & CAUSE_VALID)) |=> ((status_q & $past(ev_i & CAUSE_VALID)) == $past(ev_i & CAUSE_VALID))); // R4
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == STAT_OFS) |=> ((status_q & $past(wr_lo_i & ~ev_i)) == '0)); // R3
    AST_MASK_KEEPS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == MASK_OFS && ev_i == '0) |=> $stable(status_q)); // R6
    AST_RSVD_MASK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q & ~CAUSE_VALID) == '0); // R5
    AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(gie_q && (|(status_q & mask_q)))); // R7
    AST_MSI_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        msi_vld_o |-> irq_o); // R8
    AST_MSI_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        msi_vld_o |-> (msi_num_o inside {4'd4, 4'd5, 4'd6, 4'd9, 4'd10, 4'd11, 4'd12})); // R8
endmodule

bind hif_irq_ctrl hif_irq_ctrl_chk #(
    .ADDR_W(ADDR_W), .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_lo_i(wr_data_i[10:0]),
    .status_q(status_q), .mask_q(mask_q), .gie_q(gie_q),
    .irq_o(irq_o), .msi_vld_o(msi_vld_o), .msi_num_o(msi_num_o)
);

// File: tb/hif_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module hif_irq_ctrl_tb_top;
    localparam logic [11:0] A_STAT = 12'h520;
    localparam logic [11:0] A_MASK = 12'h528;
    localparam logic [11:0] A_CTRL = 12'h500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] ev_i = '0;
    logic        wr_en_i = 1'b0;
    logic [11:0] wr_addr_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [11:0] rd_addr_i = A_STAT;
    logic [31:0] rd_data_o;
    logic        irq_o, msi_vld_o;
    logic [3:0]  msi_num_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hif_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ev_i(ev_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .irq_o(irq_o), .msi_vld_o(msi_vld_o), .msi_num_o(msi_num_o)
    );

    typedef struct packed {
        logic [10:0] ev;
        logic        we;
        logic [11:0] wa;
        logic [31:0] wd;
        logic [11:0] ra;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{11'h001, 1'b0, 12'h000, 32'h0,        A_STAT, 32'h001, 8'd2},  // R2 set
        '{11'h018, 1'b0, 12'h000, 32'h0,        A_STAT, 32'h001, 8'd5},  // R5 reserved events
        '{11'h600, 1'b0, 12'h000, 32'h0,        A_STAT, 32'h601, 8'd2},  // R2 sticky accumulate
        '{11'h000, 1'b1, A_STAT,  32'h200,      A_STAT, 32'h401, 8'd3},  // R3 clear one
        '{11'h000, 1'b1, A_STAT,  32'h0,        A_STAT, 32'h401, 8'd3},  // R3 zero keeps
        '{11'h001, 1'b1, A_STAT,  32'h001,      A_STAT, 32'h401, 8'd4},  // R4 set wins
        '{11'h000, 1'b1, A_MASK,  32'hFFFFFFFF, A_MASK, 32'h7E7, 8'd5},  // R5 mask holes
        '{11'h000, 1'b0, 12'h000, 32'h0,        A_STAT, 32'h401, 8'd6},  // R6 mask kept cause
        '{11'h000, 1'b1, A_CTRL,  32'hFFFFFFFF, A_CTRL, 32'h080, 8'd5},  // R5 ctrl bit 7 only
        '{11'h000, 1'b1, 12'h524, 32'hFFFFFFFF, A_STAT, 32'h401, 8'd10}, // R10 stray offset
        '{11'h000, 1'b1, A_STAT,  32'h7FF,      A_STAT, 32'h000, 8'd3}   // R3 clear all
    };

    task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [10:0] ev, input logic we, input logic [11:0] wa, input logic [31:0] wd);
        ev_i = ev; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
        @(negedge clk);
        ev_i = '0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    endtask

    task automatic rd(input int req, input logic [11:0] a, input logic [31:0] exp, input string what);
        rd_addr_i = a;
        #1;
        chk(req, rd_data_o, exp, what);
    endtask

    task automatic chk_irq(input int req, input logic irq, input logic vld, input logic [3:0] num);
        chk(req, {31'd0, irq_o}, {31'd0, irq}, "irq_o");
        chk(req, {31'd0, msi_vld_o}, {31'd0, vld}, "msi_vld_o");
        if (vld) chk(req, {28'd0, msi_num_o}, {28'd0, num}, "msi_num_o");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rd(1, A_STAT, 32'h0, "reset cause");   // R1
        rd(1, A_MASK, 32'h0, "reset mask");    // R1
        rd(1, A_CTRL, 32'h0, "reset ctrl");    // R1
        rst_n = 1'b1;
        @(negedge clk);
        chk_irq(1, 1'b0, 1'b0, 4'd0);          // R1

        for (int i = 0; i < NV; i++) begin
            rd_addr_i = TBL[i].ra;
            apply(TBL[i].ev, TBL[i].we, TBL[i].wa, TBL[i].wd);
            rd(int'(TBL[i].req), TBL[i].ra, TBL[i].exp, "table readback");
        end

        // mask 0x7E7, enable on, cause clear
        apply(11'h040, 1'b0, 12'h0, 32'h0);     // queue-1-full cause (bit 6)
        chk_irq(7, 1'b0, 1'b0, 4'd0);           // R7 not yet
        @(negedge clk);
        chk_irq(8, 1'b1, 1'b1, 4'd10);          // R8 bit 6 -> 10
        apply(11'h002, 1'b0, 12'h0, 32'h0);     // completion cause (bit 1)
        chk_irq(8, 1'b1, 1'b1, 4'd10);          // R8 old vector still
        @(negedge clk);
        chk_irq(8, 1'b1, 1'b1, 4'd5);           // R8 lowest wins -> 5
        apply(11'h0, 1'b1, A_CTRL, 32'h0);      // global enable off
        chk_irq(7, 1'b1, 1'b1, 4'd5);           // R7 one-cycle lag
        @(negedge clk);
        chk_irq(7, 1'b0, 1'b0, 4'd0);           // R7 gated off
        rd(6, A_STAT, 32'h042, "ctrl write kept cause");   // R6
        apply(11'h0, 1'b1, A_CTRL, 32'h80);
        @(negedge clk);
        chk_irq(7, 1'b1, 1'b1, 4'd5);           // R7 back on
        apply(11'h0, 1'b1, A_MASK, 32'h0);
        @(negedge clk);
        chk_irq(7, 1'b0, 1'b0, 4'd0);           // R7 masked
        rd(6, A_STAT, 32'h042, "mask write kept cause");   // R6
        apply(11'h0, 1'b1, A_MASK, 32'h7FF);
        apply(11'h0, 1'b1, A_STAT, 32'h7FF);
        @(negedge clk);
        chk_irq(7, 1'b0, 1'b0, 4'd0);           // R7 all cleared
        apply(11'h200, 1'b0, 12'h0, 32'h0);     // overrun cause (bit 9)
        @(negedge clk);
        chk_irq(9, 1'b1, 1'b0, 4'd0);           // R9 level only
        apply(11'h004, 1'b0, 12'h0, 32'h0);     // message cause (bit 2)
        @(negedge clk);
        chk_irq(8, 1'b1, 1'b1, 4'd6);           // R8 bit 2 -> 6

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(1, A_STAT, 32'h0, "cause after late reset");  // R1
        rd(1, A_MASK, 32'h0, "mask after late reset");   // R1
        chk_irq(1, 1'b0, 1'b0, 4'd0);                    // R1
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_run++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule